// File: doc/BRIEF.md
# Self-Timed Manchester Word Receiver

The receiver takes a serial line that is asynchronous to `clk_i` and carries its own timing. It turns the line into a word of `2**n` bits, where `n` is supplied by the configuration side. While `mode_i` is low the block watches the line. It passes the line through a synchronizer, learns the bit period from a two-bit preamble and then takes one bit per period. It keeps adjusting its idea of the period at every accepted bit. When the line goes quiet for too long in the middle of a word, the word is dropped and a break is flagged.

Line coding: every bit carries a transition at its middle, and the bit value is the level after that transition (rising = 1, falling = 0). A transition at a bit boundary appears only between equal bits. A frame starts from an idle-high line with a falling transition. A rising transition follows one bit period later. The time between these two transitions is the first period estimate. Data bits follow directly, and the rising transition is the reference middle point for the first data bit.

Top module: `mrx_rx`

## Requirements
- R1: After reset `word_o` is all zeros, and `word_valid_o` and `break_o` are low.
- R2: A falling edge on an idle line followed by a rising edge P clocks later starts a frame when 50 <= P <= 1000, both limits included.
- R3: A preamble with P below 50 or above 1000 starts no frame. It produces neither `word_valid_o` nor `break_o`.
- R4: Each bit value is the line level after an accepted middle transition. A transition arriving sooner than three quarters of the tracked period after the last accepted middle transition is a boundary edge and is ignored.
- R5: A frame holds exactly `2**cfg_n_i` bits (cfg_n_i from 3 to 10). The first bit received ends in bit `2**n-1` of `word_o`, the last in bit 0, and all bits at or above `2**n` are zero.
- R6: `word_valid_o` is high for exactly one cycle once the last bit is accepted, and `word_o` holds the complete word in that cycle.
- R7: The tracked period is reloaded with the measured spacing at every accepted middle transition, so a frame whose bit period drifts by a few clocks per bit is still received correctly.
- R8: During reception, when no middle transition is accepted within 1.5 tracked periods, `break_o` pulses for one cycle, the word is dropped and no `word_valid_o` follows.
- R9: While `mode_i` is high the receiver stays idle. Raising it mid-frame abandons the frame without `break_o`, and no word is reported.
- R10: After a break or an abandoned frame, the next correctly formed frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | High holds the receiver idle (configuration in progress) |
| cfg_n_i | input | 4 | Word size exponent n, sampled at frame start |
| line_i | input | 1 | Asynchronous self-timed serial line |
| word_o | output | 1024 | Received word, right-aligned |
| word_valid_o | output | 1 | One-cycle strobe: `word_o` complete |
| break_o | output | 1 | One-cycle strobe: word aborted by a quiet line |

## Verification
The hardest state to reach from the ports is a break in the middle of a word: a preamble must be accepted and several bits taken before the line freezes. The bench therefore sends a partial frame and holds the line longer than 1.5 periods. It then confirms the break strobe, checks that no word strobe appears, and shows that the next frame is received. The period bounds are driven exactly at 50 and 1000 clocks and just outside them. A drifting-period frame shows that tracking keeps the boundary-edge filter and the break limit aligned with the line.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_RX   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~last_q;
  assign fall_o  = ~level_o & last_q;
endmodule

// File: rtl/mrx_period.sv
module mrx_period #(
  parameter int CNT_W = 11,
  parameter int MIN_P = 50,
  parameter int MAX_P = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] period_o,
  output logic             early_o,
  output logic             stale_o,
  output logic             short_o,
  output logic             long_o
);
  localparam int EW = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q, period_q;
  logic [EW-1:0]    elapsed, per_ext, early_lim, stale_lim;

  // elapsed = clocks since the last restart, counting the current one
  assign elapsed   = EW'(cnt_q) + EW'(1);
  assign per_ext   = EW'(period_q);
  assign early_lim = (per_ext * EW'(3)) >> 2;
  assign stale_lim = per_ext + (per_ext >> 1);

  assign early_o  = elapsed < early_lim;
  assign stale_o  = elapsed > stale_lim;
  assign short_o  = elapsed < EW'(MIN_P);
  assign long_o   = elapsed > EW'(MAX_P);
  assign period_o = period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= CNT_W'(MAX_P);
    end else begin
      if (restart_i)   cnt_q <= '0;
      else if (~&cnt_q) cnt_q <= cnt_q + CNT_W'(1);
      if (load_i)
        period_q <= (elapsed > EW'({CNT_W{1'b1}})) ? '1 : elapsed[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mrx_word.sv
module mrx_word #(
  parameter int N_MAX = 10,
  parameter int N_W   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  shift_i,
  input  logic                  bit_i,
  input  logic [N_W-1:0]        n_i,
  output logic [(1<<N_MAX)-1:0] word_o,
  output logic                  done_o
);
  localparam int W  = 1 << N_MAX;
  localparam int CW = N_MAX + 1;

  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q, target;

  assign target = {{(CW-1){1'b0}}, 1'b1} << n_i;
  assign done_o = shift_i && (cnt_q == target - CW'(1));
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      word_q <= {word_q[W-2:0], bit_i};
      cnt_q  <= done_o ? '0 : cnt_q + CW'(1);
    end
  end

  // R5: bit counter never reaches the configured word length
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < target);
endmodule

// File: rtl/mrx_rx.sv
module mrx_rx
  import mrx_pkg::*;
#(
  parameter int N_MAX       = 10,
  parameter int CNT_W       = 11,
  parameter int MIN_P       = 50,
  parameter int MAX_P       = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic [3:0]            cfg_n_i,
  input  logic                  line_i,
  output logic [(1<<N_MAX)-1:0] word_o,
  output logic                  word_valid_o,
  output logic                  break_o
);
  rx_state_e        state_q, state_d;
  logic [3:0]       n_q;
  logic             valid_q, brk_q, brk_d;
  logic             level, rise, fall, edge_seen;
  logic             restart, load, clear, shift, done;
  logic             early, stale, too_short, too_long;
  logic [CNT_W-1:0] period;

  mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .line_i,
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  mrx_period #(.CNT_W(CNT_W), .MIN_P(MIN_P), .MAX_P(MAX_P)) u_period (
    .clk_i, .rst_ni,
    .restart_i(restart), .load_i(load), .period_o(period),
    .early_o(early), .stale_o(stale), .short_o(too_short), .long_o(too_long)
  );

  mrx_word #(.N_MAX(N_MAX), .N_W(4)) u_word (
    .clk_i, .rst_ni,
    .clear_i(clear), .shift_i(shift), .bit_i(level), .n_i(n_q),
    .word_o(word_o), .done_o(done)
  );

  assign edge_seen = rise | fall;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    load    = 1'b0;
    clear   = 1'b0;
    shift   = 1'b0;
    brk_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        restart = 1'b1;
        if (!mode_i && fall) state_d = ST_SYNC;
      end
      ST_SYNC: begin
        if (mode_i || too_long) state_d = ST_IDLE;
        else if (rise) begin
          if (too_short) state_d = ST_IDLE;
          else begin
            state_d = ST_RX;
            load    = 1'b1;
            clear   = 1'b1;
            restart = 1'b1;
          end
        end
      end
      ST_RX: begin
        if (mode_i) state_d = ST_IDLE;
        else if (stale) begin
          state_d = ST_IDLE;
          brk_d   = 1'b1;
        end else if (edge_seen && !early) begin
          shift   = 1'b1;
          load    = 1'b1;
          restart = 1'b1;
          if (done) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= 4'd3;
      valid_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clear) n_q <= cfg_n_i;
      valid_q <= shift & done;
      brk_q   <= brk_d;
    end
  end

  assign word_valid_o = valid_q;
  assign break_o      = brk_q;

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r8_break_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> !valid_q);
  a_r8_break_from_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> $past(state_q) == ST_RX);
  a_r2_period_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX && $past(state_q) == ST_SYNC) |->
      (period >= CNT_W'(MIN_P) && period <= CNT_W'(MAX_P)));
  a_r9_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> (state_q == ST_IDLE && !valid_q && !brk_q));
endmodule

// File: tb/sim_mrx_rx.sv
module sim_mrx_rx;
  localparam int N_MAX = 10;
  localparam int W     = 1 << N_MAX;

  typedef struct packed {
    logic [3:0]  n;
    logic [10:0] per;
    logic [3:0]  drift;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd3,  11'd50,   4'd0, 16'hA5C3},
    '{4'd3,  11'd1000, 4'd0, 16'h1F2E},
    '{4'd4,  11'd64,   4'd0, 16'h7001},
    '{4'd5,  11'd100,  4'd3, 16'hBEEF},
    '{4'd6,  11'd77,   4'd1, 16'h0F0F},
    '{4'd10, 11'd50,   4'd0, 16'hC0DE}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic [3:0]   cfg_n_i = 4'd3;
  logic         line_i = 1'b1;
  logic [W-1:0] word_o;
  logic         word_valid_o, break_o;

  always #5 clk_i = ~clk_i;

  mrx_rx u0 (
    .clk_i, .rst_ni, .mode_i, .cfg_n_i, .line_i,
    .word_o, .word_valid_o, .break_o
  );

  int n_cmp = 0, n_bad = 0;
  int valid_cnt = 0, brk_cnt = 0, valid_wide = 0, brk_wide = 0;
  logic [W-1:0] got_word = '0;
  logic valid_d = 1'b0, brk_d = 1'b0;

  always @(negedge clk_i) begin
    if (word_valid_o) begin
      valid_cnt++;
      got_word = word_o;
      if (valid_d) valid_wide++;
    end
    if (break_o) begin
      brk_cnt++;
      if (brk_d) brk_wide++;
    end
    valid_d = word_valid_o;
    brk_d   = break_o;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  function automatic logic [W-1:0] make_word(input int n, input logic [15:0] seed);
    logic [15:0]  l = seed;
    logic [W-1:0] w = '0;
    for (int i = 0; i < (1 << n); i++) begin
      w = {w[W-2:0], l[0]};
      l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
    end
    return w;
  endfunction

  // preamble, then nsend data bits; period of bit i is per + drift*(i+1)
  task automatic send(input int n, input int per, input int drift,
                      input logic [W-1:0] w, input int nsend, input bit tail);
    int nb = 1 << n;
    int p  = per;
    line_i = 1'b1; cyc(20);
    line_i = 1'b0; cyc(per);
    line_i = 1'b1;
    for (int i = 0; i < nsend; i++) begin
      logic b;
      p = per + drift * (i + 1);
      b = w[nb-1-i];
      cyc(p / 2);     line_i = ~b;
      cyc(p - p / 2); line_i = b;
    end
    if (tail) begin
      cyc(p / 2);
      line_i = 1'b1;
    end
  endtask

  task automatic good_frame(input int n, input int per, input int drift,
                            input logic [15:0] seed, input string req);
    logic [W-1:0] exp = make_word(n, seed);
    int v0 = valid_cnt;
    int b0 = brk_cnt;
    cfg_n_i = 4'(n);
    send(n, per, drift, exp, 1 << n, 1'b1);
    cyc(10);
    check(valid_cnt == v0 + 1, req, "word strobe count", W'(valid_cnt - v0), W'(1));
    check(got_word == exp, req, "word value", got_word, exp);
    check(brk_cnt == b0, req, "no break", W'(brk_cnt - b0), W'(0));
    cyc(30);
  endtask

  task automatic quiet(input string req, input int v0, input int b0);
    check(valid_cnt == v0, req, "no word strobe", W'(valid_cnt - v0), W'(0));
    check(brk_cnt == b0, req, "no break strobe", W'(brk_cnt - b0), W'(0));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int v0, b0;
    logic [W-1:0] w;
    cyc(3);
    // R1 reset state
    check(word_o == '0, "R1", "word after reset", word_o, '0);
    check(word_valid_o == 1'b0, "R1", "valid after reset", W'(word_valid_o), '0);
    check(break_o == 1'b0, "R1", "break after reset", W'(break_o), '0);
    rst_ni = 1'b1;
    cyc(5);

    // table walk: R2 limits 50/1000, R4 decoding, R5 sizes 3..10, R6, R7 drift
    for (int k = 0; k < 6; k++) begin
      good_frame(int'(VECS[k].n), int'(VECS[k].per), int'(VECS[k].drift),
                 VECS[k].seed, (VECS[k].drift != 0) ? "R7" : "R5");
    end

    // R3 preamble too short (49)
    v0 = valid_cnt; b0 = brk_cnt;
    cfg_n_i = 4'd3;
    w = make_word(3, 16'h1234);
    send(3, 49, 0, w, 8, 1'b1);
    cyc(1200);
    quiet("R3", v0, b0);

    // R3 preamble too long (low for 1100)
    v0 = valid_cnt; b0 = brk_cnt;
    line_i = 1'b0; cyc(1100);
    line_i = 1'b1; cyc(1200);
    quiet("R3", v0, b0);

    // R8 break mid-word: 5 of 16 bits, then line frozen
    v0 = valid_cnt; b0 = brk_cnt;
    cfg_n_i = 4'd4;
    w = make_word(4, 16'h5A5A);
    send(4, 80, 0, w, 5, 1'b0);
    cyc(250);
    check(brk_cnt == b0 + 1, "R8", "break strobe count", W'(brk_cnt - b0), W'(1));
    check(valid_cnt == v0, "R8", "no word after break", W'(valid_cnt - v0), W'(0));
    line_i = 1'b1; cyc(1200);

    // R10 recovery after break
    good_frame(4, 80, 0, 16'h3C3C, "R10");

    // R9 mode high across a whole frame
    v0 = valid_cnt; b0 = brk_cnt;
    mode_i = 1'b1;
    cfg_n_i = 4'd3;
    w = make_word(3, 16'h0BAD);
    send(3, 60, 0, w, 8, 1'b1);
    cyc(1200);
    quiet("R9", v0, b0);
    mode_i = 1'b0;
    cyc(5);

    // R9 mode raised mid-frame: abandoned, no break
    v0 = valid_cnt; b0 = brk_cnt;
    send(3, 60, 0, w, 3, 1'b0);
    cyc(5);
    mode_i = 1'b1; cyc(10);
    mode_i = 1'b0; cyc(300);
    quiet("R9", v0, b0);
    line_i = 1'b1; cyc(1200);

    // R10 recovery after abandon
    good_frame(5, 120, 0, 16'h9E37, "R10");

    // R6 / R8 strobe widths over the whole run
    check(valid_wide == 0, "R6", "word strobe wider than 1", W'(valid_wide), W'(0));
    check(brk_wide == 0, "R8", "break strobe wider than 1", W'(brk_wide), W'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule